// File: doc/BRIEF.md
# Two-Tier Memory Access Permission Checker

This block decides, for each bus request, whether it may proceed. A request names an address, the master port it came from, an owner ID, the access kinds it needs (read, write, execute) and whether it is a secure access. The block compares it against a bank of base regions and a smaller bank of override regions. It returns an allow or deny verdict, the index of the base region that decided it and the override that changed it, if any. A denied verdict also produces a one-cycle deny pulse that carries the region index.

Base regions match on a page address under a mask. Override regions match an inclusive page range and replace only the permission bits that their selection mask names. Both banks are programmed through one register write port. Any rule can be locked, and a locked rule keeps its settings until reset. Requests come in on a valid/ready channel and verdicts go out on one. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the verdict register is empty or is being drained in the same cycle. A verdict stays on the outputs, unchanged, until `rsp_ready` is seen high.

Top module: `mem_perm_check`

## Requirements
- R1: The low 12 bits of start, mask and end values written to a rule are discarded, so all rule addresses are 4 KiB pages. The low 12 bits of the request address never affect the verdict.
- R2: A base region matches when `(page(addr) ^ page(start)) & page(mask)` is zero. When several enabled base regions match, the lowest index decides and is reported.
- R3: Permission bits are [0] read, [1] write, [2] execute, [3] secure. A request is denied if any access kind it asks for has its bit clear, or if `req_sec` differs from bit 3.
- R4: A rule applies only if bit `req_port` of its port mask is set and its owner equals `req_owner`.
- R5: A rule whose enable bit is clear never matches. A request that matches no base region is denied, with `rsp_region_hit` low.
- R6: Control word bits are [0] enable, [1] lock, [2] ignore address bit 28 (override bank only). After lock is written as 1, every later write to that rule is ignored until reset.
- R7: An override matches when its start page ≤ page(addr) ≤ its end page, both ends included. It applies only when a base region matched, and the lowest matching index wins. The final permission is `(base & ~sel) | (ovr & sel)`.
- R8: When an override's ignore bit is set, address bit 28 is cleared in the request, the start and the end before that override compares them.
- R9: A verdict appears one cycle after its request is accepted. `deny_pulse` is high for exactly that one cycle when the verdict is deny, with `deny_idx` equal to the matched region (0 if none). A held verdict stays stable and blocks new requests while `rsp_ready` is low.
- R10: After reset no verdict is pending, `deny_pulse` is low, every rule is disabled and unlocked, and `req_ready` is high.
- R11: Writes select the bank with `cfg_tier` (0 base, 1 override), the rule with `cfg_idx` and the field with `cfg_field`: 0 control, 1 start, 2 mask or end, 3 permissions, 4 override selection mask, 5 owner, 6 port mask. A write takes effect for requests accepted from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_tier | input | 1 | 0 base bank, 1 override bank |
| cfg_idx | input | CIDX_W | Rule index within the bank |
| cfg_field | input | 3 | Field selector |
| cfg_data | input | ADDR_W | Write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | ADDR_W | Request address |
| req_port | input | PORT_W | Requesting master port |
| req_owner | input | OWNER_W | Requesting owner ID |
| req_rd | input | 1 | Read access requested |
| req_wr | input | 1 | Write access requested |
| req_ex | input | 1 | Execute access requested |
| req_sec | input | 1 | Secure access |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Verdict consumer ready |
| rsp_allow | output | 1 | 1 allow, 0 deny |
| rsp_region_hit | output | 1 | A base region matched |
| rsp_region_idx | output | RIDX_W | Deciding base region |
| rsp_ovr_hit | output | 1 | An override changed the permissions |
| rsp_ovr_idx | output | OIDX_W | Applied override |
| deny_pulse | output | 1 | One-cycle deny indication |
| deny_idx | output | RIDX_W | Region index carried by the deny pulse |

## Verification
The assertions check on every cycle that a deny pulse only comes with a pending deny verdict and carries its index. They also check that a verdict with no region hit is never an allow, that an override is never reported without a base hit, that a held verdict is stable and blocks intake, and that lock bits never clear. The address arithmetic needs the bench's scenarios to show it: mask matching, inclusive range ends, bit-28 folding, lowest-index priority, masked permission merging, secure mismatch, and writes ignored after lock. The bench runs directed corner cases and then a long random mix of configurations and requests, compared against an independent model.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [2:0] {
    F_CTRL  = 3'd0,
    F_START = 3'd1,
    F_LIMIT = 3'd2,
    F_PERM  = 3'd3,
    F_PSEL  = 3'd4,
    F_OWNER = 3'd5,
    F_PORTS = 3'd6
  } rule_field_e;

  localparam int PB_RD  = 0;
  localparam int PB_WR  = 1;
  localparam int PB_EX  = 2;
  localparam int PB_SEC = 3;

  localparam int CB_EN   = 0;
  localparam int CB_LOCK = 1;
  localparam int CB_IGN  = 2;
endpackage

// File: rtl/perm_rule_bank.sv
module perm_rule_bank
  import mpc_pkg::*;
#(
  parameter int N        = 4,
  parameter int IS_OVR   = 0,
  parameter int ADDR_W   = 32,
  parameter int OWNER_W  = 4,
  parameter int N_PORT   = 8,
  parameter int PORT_W   = 3,
  parameter int IDX_W    = 2,
  parameter int IGN_BIT  = 28,
  parameter int PAGE_LSB = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  rule_field_e                wr_field,
  input  logic [ADDR_W-1:0]          wr_data,
  input  logic [ADDR_W-PAGE_LSB-1:0] q_page,
  input  logic [PORT_W-1:0]          q_port,
  input  logic [OWNER_W-1:0]         q_owner,
  output logic [N-1:0]               hit,
  output logic [N-1:0]               locked,
  output logic [3:0]                 perm_val [N],
  output logic [3:0]                 perm_sel [N]
);
  localparam int PG_W    = ADDR_W - PAGE_LSB;
  localparam int IGN_POS = IGN_BIT - PAGE_LSB;

  for (genvar g = 0; g < N; g++) begin : g_rule
    logic                en_q, lock_q, wr_ok, in_range;
    logic [PG_W-1:0]     start_q, lim_q;
    logic [3:0]          perm_q;
    logic [OWNER_W-1:0]  owner_q;
    logic [N_PORT-1:0]   ports_q;

    // a locked rule swallows every write until reset
    assign wr_ok = wr_en && (wr_idx == IDX_W'(g)) && !lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q    <= 1'b0;
        lock_q  <= 1'b0;
        start_q <= '0;
        lim_q   <= '0;
        perm_q  <= '0;
        owner_q <= '0;
        ports_q <= '0;
      end else if (wr_ok) begin
        case (wr_field)
          F_CTRL: begin
            en_q   <= wr_data[CB_EN];
            lock_q <= wr_data[CB_LOCK];
          end
          F_START: start_q <= wr_data[ADDR_W-1:PAGE_LSB];
          F_LIMIT: lim_q   <= wr_data[ADDR_W-1:PAGE_LSB];
          F_PERM:  perm_q  <= wr_data[3:0];
          F_OWNER: owner_q <= wr_data[OWNER_W-1:0];
          F_PORTS: ports_q <= wr_data[N_PORT-1:0];
          default: ;
        endcase
      end
    end

    if (IS_OVR != 0) begin : g_ovr
      logic            ign_q;
      logic [3:0]      sel_q;
      logic [PG_W-1:0] keep, pg_m, st_m, end_m;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ign_q <= 1'b0;
          sel_q <= '0;
        end else if (wr_ok) begin
          if (wr_field == F_CTRL) ign_q <= wr_data[CB_IGN];
          if (wr_field == F_PSEL) sel_q <= wr_data[3:0];
        end
      end

      assign keep  = ign_q ? ~(PG_W'(1) << IGN_POS) : '1;
      assign pg_m  = q_page  & keep;
      assign st_m  = start_q & keep;
      assign end_m = lim_q   & keep;
      assign in_range = (pg_m >= st_m) && (pg_m <= end_m);
      assign perm_sel[g] = sel_q;
    end else begin : g_base
      assign in_range    = ((q_page ^ start_q) & lim_q) == '0;
      assign perm_sel[g] = 4'hF;
    end

    assign hit[g]      = en_q && ports_q[q_port] && (owner_q == q_owner) && in_range;
    assign locked[g]   = lock_q;
    assign perm_val[g] = perm_q;
  end
endmodule

// File: rtl/prio_first.sv
module prio_first #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/mem_perm_check.sv
module mem_perm_check
  import mpc_pkg::*;
#(
  parameter int N_REGION = 4,
  parameter int N_OVR    = 2,
  parameter int N_PORT   = 8,
  parameter int ADDR_W   = 32,
  parameter int OWNER_W  = 4,
  parameter int IGN_BIT  = 28,
  parameter int PAGE_LSB = 12,
  localparam int MAX_N   = (N_REGION > N_OVR) ? N_REGION : N_OVR,
  localparam int CIDX_W  = (MAX_N > 1) ? $clog2(MAX_N) : 1,
  localparam int RIDX_W  = (N_REGION > 1) ? $clog2(N_REGION) : 1,
  localparam int OIDX_W  = (N_OVR > 1) ? $clog2(N_OVR) : 1,
  localparam int PORT_W  = (N_PORT > 1) ? $clog2(N_PORT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_tier,
  input  logic [CIDX_W-1:0]  cfg_idx,
  input  logic [2:0]         cfg_field,
  input  logic [ADDR_W-1:0]  cfg_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [PORT_W-1:0]  req_port,
  input  logic [OWNER_W-1:0] req_owner,
  input  logic               req_rd,
  input  logic               req_wr,
  input  logic               req_ex,
  input  logic               req_sec,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_allow,
  output logic               rsp_region_hit,
  output logic [RIDX_W-1:0]  rsp_region_idx,
  output logic               rsp_ovr_hit,
  output logic [OIDX_W-1:0]  rsp_ovr_idx,
  output logic               deny_pulse,
  output logic [RIDX_W-1:0]  deny_idx
);
  localparam int PG_W = ADDR_W - PAGE_LSB;

  logic [PG_W-1:0]     q_page;
  logic [N_REGION-1:0] base_hit, base_lock;
  logic [N_OVR-1:0]    ovr_hit, ovr_lock;
  logic [3:0]          base_val [N_REGION];
  logic [3:0]          base_sel [N_REGION];
  logic [3:0]          ovr_val  [N_OVR];
  logic [3:0]          ovr_sel  [N_OVR];
  logic                b_any, o_any, o_use, allow_c, fire;
  logic [RIDX_W-1:0]   b_idx;
  logic [OIDX_W-1:0]   o_idx;
  logic [3:0]          p_base, p_final;
  rule_field_e         field;

  assign q_page = req_addr[ADDR_W-1:PAGE_LSB];
  assign field  = rule_field_e'(cfg_field);

  perm_rule_bank #(
    .N(N_REGION), .IS_OVR(0), .ADDR_W(ADDR_W), .OWNER_W(OWNER_W), .N_PORT(N_PORT),
    .PORT_W(PORT_W), .IDX_W(CIDX_W), .IGN_BIT(IGN_BIT), .PAGE_LSB(PAGE_LSB)
  ) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && !cfg_tier), .wr_idx(cfg_idx),
    .wr_field(field), .wr_data(cfg_data), .q_page(q_page), .q_port(req_port),
    .q_owner(req_owner), .hit(base_hit), .locked(base_lock),
    .perm_val(base_val), .perm_sel(base_sel)
  );

  perm_rule_bank #(
    .N(N_OVR), .IS_OVR(1), .ADDR_W(ADDR_W), .OWNER_W(OWNER_W), .N_PORT(N_PORT),
    .PORT_W(PORT_W), .IDX_W(CIDX_W), .IGN_BIT(IGN_BIT), .PAGE_LSB(PAGE_LSB)
  ) u_ovr (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && cfg_tier), .wr_idx(cfg_idx),
    .wr_field(field), .wr_data(cfg_data), .q_page(q_page), .q_port(req_port),
    .q_owner(req_owner), .hit(ovr_hit), .locked(ovr_lock),
    .perm_val(ovr_val), .perm_sel(ovr_sel)
  );

  prio_first #(.N(N_REGION), .W(RIDX_W)) u_bpick (.vec(base_hit), .any(b_any), .idx(b_idx));
  prio_first #(.N(N_OVR),    .W(OIDX_W)) u_opick (.vec(ovr_hit),  .any(o_any), .idx(o_idx));

  // same merge form for both tiers: base selection is all ones
  assign p_base  = base_val[b_idx] & base_sel[b_idx];
  assign o_use   = b_any && o_any;
  assign p_final = o_use ? ((p_base & ~ovr_sel[o_idx]) | (ovr_val[o_idx] & ovr_sel[o_idx]))
                         : p_base;

  assign allow_c = b_any
                && (!req_rd || p_final[PB_RD])
                && (!req_wr || p_final[PB_WR])
                && (!req_ex || p_final[PB_EX])
                && (req_sec == p_final[PB_SEC]);

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_allow      <= 1'b0;
      rsp_region_hit <= 1'b0;
      rsp_region_idx <= '0;
      rsp_ovr_hit    <= 1'b0;
      rsp_ovr_idx    <= '0;
      deny_pulse     <= 1'b0;
      deny_idx       <= '0;
    end else begin
      deny_pulse <= fire && !allow_c;
      if (fire) begin
        rsp_valid      <= 1'b1;
        rsp_allow      <= allow_c;
        rsp_region_hit <= b_any;
        rsp_region_idx <= b_idx;
        rsp_ovr_hit    <= o_use;
        rsp_ovr_idx    <= o_idx;
        deny_idx       <= b_idx;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mem_perm_check_sva.sv
module mem_perm_check_sva #(
  parameter int N_REGION = 4,
  parameter int N_OVR    = 2,
  parameter int RIDX_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic                rsp_allow,
  input logic                rsp_region_hit,
  input logic [RIDX_W-1:0]   rsp_region_idx,
  input logic                rsp_ovr_hit,
  input logic                deny_pulse,
  input logic [RIDX_W-1:0]   deny_idx,
  input logic [N_REGION-1:0] base_lock,
  input logic [N_OVR-1:0]    ovr_lock
);
  a_r9_deny_has_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    deny_pulse |-> (rsp_valid && !rsp_allow));

  a_r9_deny_idx_matches: assert property (@(posedge clk) disable iff (!rst_n)
    deny_pulse |-> (deny_idx == rsp_region_idx));

  a_r5_no_region_no_allow: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_region_hit) |-> !rsp_allow);

  a_r7_ovr_needs_base: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ovr_hit) |-> rsp_region_hit);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_allow)
                                   && $stable(rsp_region_idx) && $stable(rsp_ovr_hit)));

  a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r6_base_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((base_lock & $past(base_lock)) == $past(base_lock)));

  a_r6_ovr_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovr_lock & $past(ovr_lock)) == $past(ovr_lock)));
endmodule

bind mem_perm_check mem_perm_check_sva #(
  .N_REGION(N_REGION), .N_OVR(N_OVR), .RIDX_W(RIDX_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_allow(rsp_allow), .rsp_region_hit(rsp_region_hit),
  .rsp_region_idx(rsp_region_idx), .rsp_ovr_hit(rsp_ovr_hit), .deny_pulse(deny_pulse),
  .deny_idx(deny_idx), .base_lock(base_lock), .ovr_lock(ovr_lock)
);

// File: tb/sim_mem_perm_check.sv
module sim_mem_perm_check;
  localparam int CLK_T = 10;
  localparam int NR = 4;
  localparam int NO = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_tier = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [2:0]  cfg_field = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_port = '0;
  logic [3:0]  req_owner = '0;
  logic        req_rd = 1'b0, req_wr = 1'b0, req_ex = 1'b0, req_sec = 1'b0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_allow, rsp_region_hit, rsp_ovr_hit;
  logic [1:0]  rsp_region_idx, deny_idx;
  logic [0:0]  rsp_ovr_idx;
  logic        deny_pulse;

  int errors = 0;
  int checks = 0;

  always #(CLK_T/2) clk = ~clk;

  mem_perm_check u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tier(cfg_tier), .cfg_idx(cfg_idx),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_port(req_port), .req_owner(req_owner), .req_rd(req_rd),
    .req_wr(req_wr), .req_ex(req_ex), .req_sec(req_sec), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_allow(rsp_allow), .rsp_region_hit(rsp_region_hit),
    .rsp_region_idx(rsp_region_idx), .rsp_ovr_hit(rsp_ovr_hit), .rsp_ovr_idx(rsp_ovr_idx),
    .deny_pulse(deny_pulse), .deny_idx(deny_idx)
  );

  // reference model state, one entry per rule of each tier
  logic        m_en [2][NR], m_lock [2][NR], m_ign [2][NR];
  logic [31:0] m_start [2][NR], m_lim [2][NR], m_ports [2][NR];
  logic [3:0]  m_perm [2][NR], m_sel [2][NR], m_owner [2][NR];

  logic e_allow, e_rhit, e_ohit;
  int   e_ridx, e_oidx;

  task automatic model_reset();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < NR; i++) begin
        m_en[t][i] = 0; m_lock[t][i] = 0; m_ign[t][i] = 0;
        m_start[t][i] = 0; m_lim[t][i] = 0; m_ports[t][i] = 0;
        m_perm[t][i] = 0; m_sel[t][i] = 0; m_owner[t][i] = 0;
      end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg(input int tier, input int idx, input int field, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_tier = tier[0]; cfg_idx = idx[1:0]; cfg_field = field[2:0]; cfg_data = d;
    if (!(tier == 1 && idx >= NO) && !m_lock[tier][idx]) begin
      case (field)
        0: begin m_en[tier][idx] = d[0]; m_lock[tier][idx] = d[1];
                 if (tier == 1) m_ign[tier][idx] = d[2]; end
        1: m_start[tier][idx] = d & 32'hFFFF_F000;
        2: m_lim[tier][idx]   = d & 32'hFFFF_F000;
        3: m_perm[tier][idx]  = d[3:0];
        4: if (tier == 1) m_sel[tier][idx] = d[3:0];
        5: m_owner[tier][idx] = d[3:0];
        6: m_ports[tier][idx] = {24'b0, d[7:0]};
        default: ;
      endcase
    end
    @(posedge clk);
    #1 cfg_we = 0;
  endtask

  task automatic rule(input int tier, input int idx, input logic [31:0] st, input logic [31:0] lim,
                      input logic [3:0] perm, input logic [3:0] sel, input logic [3:0] own,
                      input logic [7:0] ports, input logic [2:0] ctrl);
    cfg(tier, idx, 1, st);
    cfg(tier, idx, 2, lim);
    cfg(tier, idx, 3, {28'b0, perm});
    cfg(tier, idx, 4, {28'b0, sel});
    cfg(tier, idx, 5, {28'b0, own});
    cfg(tier, idx, 6, {24'b0, ports});
    cfg(tier, idx, 0, {29'b0, ctrl});
  endtask

  task automatic predict(input logic [31:0] a, input int port, input logic [3:0] own,
                         input bit rd, input bit wr, input bit ex, input bit sec);
    logic [3:0]  p;
    logic [31:0] keep, am;
    e_rhit = 0; e_ohit = 0; e_ridx = 0; e_oidx = 0;
    for (int i = NR - 1; i >= 0; i--)
      if (m_en[0][i] && m_ports[0][i][port] && m_owner[0][i] == own &&
          (((a ^ m_start[0][i]) & m_lim[0][i] & 32'hFFFF_F000) == 0)) begin
        e_rhit = 1; e_ridx = i;
      end
    p = m_perm[0][e_ridx];
    if (e_rhit) begin
      for (int j = NO - 1; j >= 0; j--) begin
        keep = m_ign[1][j] ? 32'hEFFF_FFFF : 32'hFFFF_FFFF;
        am = a & 32'hFFFF_F000 & keep;
        if (m_en[1][j] && m_ports[1][j][port] && m_owner[1][j] == own &&
            am >= (m_start[1][j] & keep) && am <= (m_lim[1][j] & keep)) begin
          e_ohit = 1; e_oidx = j;
        end
      end
      if (e_ohit) p = (p & ~m_sel[1][e_oidx]) | (m_perm[1][e_oidx] & m_sel[1][e_oidx]);
    end
    e_allow = e_rhit && (!rd || p[0]) && (!wr || p[1]) && (!ex || p[2]) && (sec == p[3]);
  endtask

  task automatic txn(input string tag, input logic [31:0] a, input int port, input logic [3:0] own,
                     input bit rd, input bit wr, input bit ex, input bit sec);
    predict(a, port, own, rd, wr, ex, sec);
    @(negedge clk);
    req_valid = 1; rsp_ready = 1; req_addr = a; req_port = port[2:0]; req_owner = own;
    req_rd = rd; req_wr = wr; req_ex = ex; req_sec = sec;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, {tag, " R9 verdict after one cycle"}, rsp_valid, 1);
    chk(rsp_allow === e_allow, {tag, " allow"}, rsp_allow, e_allow);
    chk(rsp_region_hit === e_rhit, {tag, " region hit"}, rsp_region_hit, e_rhit);
    if (e_rhit) chk(rsp_region_idx === e_ridx[1:0], {tag, " region idx"}, rsp_region_idx, e_ridx);
    chk(rsp_ovr_hit === e_ohit, {tag, " ovr hit"}, rsp_ovr_hit, e_ohit);
    if (e_ohit) chk(rsp_ovr_idx === e_oidx[0:0], {tag, " ovr idx"}, rsp_ovr_idx, e_oidx);
    chk(deny_pulse === !e_allow, {tag, " R9 deny pulse"}, deny_pulse, !e_allow);
    if (!e_allow) chk(deny_idx === e_ridx[1:0], {tag, " R9 deny idx"}, deny_idx, e_ridx);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model_reset();
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10 no verdict in reset", rsp_valid, 0);
    chk(deny_pulse === 1'b0, "R10 no deny pulse in reset", deny_pulse, 0);
    chk(req_ready === 1'b1, "R10 ready in reset", req_ready, 1);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_T * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] hold_allow;
    void'($urandom(32'h5EED_0042));
    do_reset();

    txn("R5 empty config", 32'h2000_1000, 0, 1, 1, 0, 0, 0);

    // R1: start written with low bits set still means page 0x20000
    rule(0, 0, 32'h2000_0ABC, 32'hFFFF_0000, 4'h3, 4'h0, 1, 8'h05, 3'b001);
    rule(0, 1, 32'h2000_0000, 32'hF000_0000, 4'h1, 4'h0, 1, 8'hFF, 3'b001);
    txn("R1 R2 lowest wins", 32'h2000_1FFF, 0, 1, 1, 0, 0, 0);
    txn("R3 write clear", 32'h2001_0000, 0, 1, 1, 1, 0, 0);
    txn("R4 port gate", 32'h2000_1234, 1, 1, 1, 0, 0, 0);
    txn("R4 owner gate", 32'h2000_1234, 0, 2, 1, 0, 0, 0);
    txn("R3 secure mismatch", 32'h2000_1234, 0, 1, 1, 0, 0, 1);
    txn("R3 exec clear", 32'h2000_1234, 0, 1, 0, 0, 1, 0);

    rule(1, 0, 32'h2000_2000, 32'h2000_3000, 4'h4, 4'h6, 1, 8'hFF, 3'b001);
    txn("R7 inclusive end exec", 32'h2000_3FFC, 0, 1, 0, 0, 1, 0);
    txn("R7 masked write clear", 32'h2000_3FFC, 0, 1, 0, 1, 0, 0);
    txn("R7 past end", 32'h2000_4000, 0, 1, 0, 0, 1, 0);
    rule(1, 1, 32'h2000_2000, 32'h2000_2000, 4'h6, 4'h6, 1, 8'hFF, 3'b001);
    txn("R7 lowest override wins", 32'h2000_2000, 0, 1, 0, 1, 0, 0);

    rule(0, 2, 32'h0000_0000, 32'h0000_0000, 4'h1, 4'h0, 1, 8'hFF, 3'b001);
    rule(1, 1, 32'h0000_5000, 32'h0000_5000, 4'h2, 4'h2, 1, 8'hFF, 3'b101);
    txn("R8 bit28 ignored", 32'h1000_5000, 0, 1, 0, 1, 0, 0);
    cfg(1, 1, 0, 32'h1);
    txn("R8 bit28 compared", 32'h1000_5000, 0, 1, 0, 1, 0, 0);
    cfg(0, 2, 0, 32'h0);
    txn("R5 disabled rule", 32'h1000_5000, 0, 1, 1, 0, 0, 0);

    rule(0, 3, 32'h3000_0000, 32'hF000_0000, 4'h1, 4'h0, 1, 8'hFF, 3'b011);
    cfg(0, 3, 3, 32'hF);
    cfg(0, 3, 0, 32'h0);
    txn("R6 locked keeps enable", 32'h3000_0000, 0, 1, 1, 0, 0, 0);
    txn("R6 locked keeps perm", 32'h3000_0000, 0, 1, 0, 1, 0, 0);

    // R9 back-pressure: verdict held, intake blocked
    predict(32'h3000_0000, 0, 7, 1, 0, 0, 0);
    @(negedge clk);
    req_valid = 1; rsp_ready = 0; req_addr = 32'h3000_0000; req_port = 0; req_owner = 7;
    req_rd = 1; req_wr = 0; req_ex = 0; req_sec = 0;
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_allow === e_allow, "R9 held verdict", rsp_allow, e_allow);
    chk(deny_pulse === 1'b1, "R9 deny pulse first cycle", deny_pulse, 1);
    chk(req_ready === 1'b0, "R9 full blocks intake", req_ready, 0);
    hold_allow = {31'b0, rsp_allow};
    @(negedge clk);
    chk(deny_pulse === 1'b0, "R9 deny pulse one cycle", deny_pulse, 0);
    chk(rsp_valid === 1'b1 && rsp_allow === hold_allow[0], "R9 verdict stable", rsp_allow, hold_allow);
    chk(req_ready === 1'b0, "R9 still blocked", req_ready, 0);
    req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 drained", rsp_valid, 0);

    do_reset();
    cfg(0, 3, 0, 32'h1);
    cfg(0, 3, 5, 32'h1);
    cfg(0, 3, 6, 32'hFF);
    cfg(0, 3, 3, 32'h1);
    txn("R10 R6 lock cleared by reset", 32'h5000_0000, 0, 1, 1, 0, 0, 0);

    // R11 R2 R7 random mix against the model
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) begin
        for (int k = 0; k < 24; k++) begin
          int tier, idx, field;
          logic [31:0] d;
          tier = $urandom % 2;
          idx = (tier == 1) ? $urandom % NO : $urandom % NR;
          field = $urandom % 7;
          case (field)
            0: d = $urandom % 8 & 32'h5;
            1: d = (($urandom % 4) << 28) | (($urandom % 16) << 12) | ($urandom % 4096);
            2: if (tier == 0) begin
                 case ($urandom % 4)
                   0: d = 32'hFFFF_F000;
                   1: d = 32'hF000_F000;
                   2: d = 32'h3000_0000;
                   default: d = 32'h0;
                 endcase
               end else d = (($urandom % 4) << 28) | (($urandom % 16) << 12);
            5: d = $urandom % 2;
            6: d = $urandom % 256;
            default: d = $urandom % 16;
          endcase
          cfg(tier, idx, field, d);
        end
      end
      txn("R11 random", (($urandom % 4) << 28) | (($urandom % 16) << 12) | ($urandom % 4096),
          $urandom % 8, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule